// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block turns the differential data pair of a low-speed USB link into a stream of received bytes. It runs from a clock several times faster than the line bit rate (eight samples per bit by default). The two line inputs are first passed through a synchroniser. A sample-phase counter is then re-centred on every level change of the minus line, so bit samples stay near the middle of each bit even when the far transmitter's clock is off by about one percent.

A packet begins with a falling edge on the minus line out of the idle J state. The receiver then walks the alternating sync bits until it sees two K bits in a row. After that it NRZI-decodes each bit, drops the bit that follows six consecutive decoded ones, and packs data bits into bytes starting with the least significant bit. It ends the packet on an SE0 that lasts two bit slots. A byte budget loaded at packet start guards the consumer, and an oversized packet is aborted with an overflow pulse. While the local transmitter owns the bus, the receiver is held in its idle search state.

Top module: `usbls_rx`

## Requirements
- R1: While reset is asserted and after its release with an idle line, rx_byte_vld, rx_pkt_end and rx_overflow are low.
- R2: A packet is accepted only after a J-to-K falling edge on line_dm followed by bit samples that end in two consecutive K bits (K: dm=0, dp=1). Two consecutive J samples, an SE0 sample, or SYNC_SLOTS samples without such a pair return the receiver to idle search with no output.
- R3: Each data bit decodes to 1 when the sampled line_dm level equals the previous bit's level and to 0 when it differs. Bits fill a byte from bit 0 upward, and each completed byte is presented on rx_byte with rx_byte_vld high for exactly one cycle.
- R4: After six consecutive decoded 1s among the data bits, the next bit slot is discarded and contributes nothing to the byte. The run count is restarted after the discarded slot.
- R5: Packets are received correctly when the transmitter bit period deviates by up to ±1% from OVS clock cycles, because every line_dm level change re-centres the sampling point.
- R6: Two successive SE0 bit slots (dm=0, dp=0) end the packet with a one-cycle rx_pkt_end pulse. If k data bits (0<k<8) of an unfinished byte are held, they are output in the same cycle on rx_byte[k-1:0] with the upper bits zero and rx_byte_vld high.
- R7: A single SE0 bit slot that is followed by a J or K slot produces no data bit and does not end the packet.
- R8: At most MAX_BYTES bytes are output per packet. The next completed byte raises a one-cycle rx_overflow instead of rx_byte_vld and gives no rx_pkt_end. The receiver then ignores the line until an SE0 slot, after which the next packet is received normally.
- R9: While tx_active is high, the receiver returns to idle search and rx_byte_vld, rx_pkt_end and rx_overflow stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OVS cycles per nominal bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Local transmitter drives the bus; holds the receiver idle |
| line_dp | input | 1 | Plus line of the pair, asynchronous |
| line_dm | input | 1 | Minus line of the pair, asynchronous |
| rx_byte_vld | output | 1 | One-cycle strobe for rx_byte |
| rx_byte | output | 8 | Received byte, first bit on the wire in bit 0 |
| rx_pkt_end | output | 1 | One-cycle pulse at end of packet |
| rx_overflow | output | 1 | One-cycle pulse when the byte budget is exceeded |

## Verification
Bytes of all zeros make the line toggle every bit, while bytes of all ones and runs straddling byte boundaries force bit removal. Comparing the two separates the NRZI polarity from the stuffing logic. Random packets sent with bit periods one percent long and one percent short show whether re-centring keeps samples inside the bit, since a stretch of six ones gives no edge for seven bits. Directed packets with a trailing partial byte, a lone SE0 slot, an oversized length, sync patterns that never reach the double K, and an active transmitter each target one end-of-packet or rejection path, and are followed by clean packets to show recovery.

// File: rtl/usbls_rx_pkg.sv
`timescale 1ps/1ps
package usbls_rx_pkg;
  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_SYNC  = 2'd1,
    RX_DATA  = 2'd2,
    RX_DRAIN = 2'd3
  } rx_state_e;

  localparam int STUFF_RUN = 6;
  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/usbls_rx_sync.sv
`timescale 1ps/1ps
module usbls_rx_sync #(
  parameter int             WIDTH   = 2,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= g_stage[s-1].q;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/usbls_rx_phase.sv
`timescale 1ps/1ps
module usbls_rx_phase #(
  parameter int OVS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dm_i,
  output logic strobe_o,
  output logic edge_o
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  logic          dm_q;
  logic [CW-1:0] cnt_q, cnt_d;

  assign edge_o = dm_i ^ dm_q;

  always_comb begin
    if (edge_o)                        cnt_d = CW'(1);
    else if (cnt_q == CW'(OVS - 1))    cnt_d = '0;
    else                               cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dm_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      dm_q  <= dm_i;
      cnt_q <= cnt_d;
    end
  end

  assign strobe_o = (cnt_q == CW'(HALF));

  // R5: one sample per bit, never right after a re-centring edge
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
  assert_recenter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !strobe_o);
endmodule

// File: rtl/usbls_rx_deser.sv
`timescale 1ps/1ps
module usbls_rx_deser
  import usbls_rx_pkg::*;
#(
  parameter int MAX_BYTES  = 16,
  parameter int SYNC_SLOTS = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_active_i,
  input  logic       strobe_i,
  input  logic       edge_i,
  input  logic       dm_i,
  input  logic       dp_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       pkt_end_o,
  output logic       overflow_o
);
  localparam int CNT_W  = $clog2(MAX_BYTES + 1);
  localparam int SLOT_W = $clog2(SYNC_SLOTS + 1);
  localparam int BIT_W  = $clog2(BYTE_BITS);
  localparam int RUN_W  = $clog2(STUFF_RUN + 1);

  rx_state_e       state_q, state_d;
  logic            prev_lvl_q, prev_lvl_d;
  logic            last_k_q, last_k_d;
  logic            last_j_q, last_j_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [RUN_W-1:0]  ones_q, ones_d;
  logic [BIT_W-1:0]  nbits_q, nbits_d;
  logic [7:0]      acc_q, acc_d, acc_bit;
  logic [CNT_W-1:0] left_q, left_d;
  logic            se0_q, se0_d;
  logic            vld_q, vld_d;
  logic [7:0]      data_q, data_d;
  logic            end_q, end_d;
  logic            ovf_q, ovf_d;

  logic is_j, is_k, is_se0, bit_v;

  assign is_j   =  dm_i & ~dp_i;
  assign is_k   = ~dm_i &  dp_i;
  assign is_se0 = ~dm_i & ~dp_i;
  assign bit_v  = ~(dm_i ^ prev_lvl_q);

  always_comb begin
    acc_bit          = acc_q;
    acc_bit[nbits_q] = bit_v;
  end

  always_comb begin
    state_d    = state_q;
    prev_lvl_d = prev_lvl_q;
    last_k_d   = last_k_q;
    last_j_d   = last_j_q;
    slot_d     = slot_q;
    ones_d     = ones_q;
    nbits_d    = nbits_q;
    acc_d      = acc_q;
    left_d     = left_q;
    se0_d      = se0_q;
    data_d     = data_q;
    vld_d      = 1'b0;
    end_d      = 1'b0;
    ovf_d      = 1'b0;
    if (tx_active_i) begin
      state_d = RX_HUNT;
    end else begin
      unique case (state_q)
        RX_HUNT: begin
          if (edge_i && !dm_i && dp_i) begin
            state_d  = RX_SYNC;
            slot_d   = '0;
            last_k_d = 1'b0;
            last_j_d = 1'b0;
          end
        end
        RX_SYNC: begin
          if (strobe_i) begin
            slot_d   = slot_q + SLOT_W'(1);
            last_k_d = is_k;
            last_j_d = is_j;
            if (is_k && last_k_q) begin
              state_d    = RX_DATA;
              prev_lvl_d = 1'b0;
              ones_d     = '0;
              nbits_d    = '0;
              acc_d      = '0;
              left_d     = CNT_W'(MAX_BYTES);
              se0_d      = 1'b0;
            end else if ((is_j && last_j_q) || is_se0 ||
                         slot_q == SLOT_W'(SYNC_SLOTS - 1)) begin
              state_d = RX_HUNT;
            end
          end
        end
        RX_DATA: begin
          if (strobe_i) begin
            if (is_se0) begin
              if (se0_q) begin
                state_d = RX_HUNT;
                se0_d   = 1'b0;
                if (nbits_q == '0) begin
                  end_d = 1'b1;
                end else if (left_q == '0) begin
                  ovf_d = 1'b1;
                end else begin
                  vld_d  = 1'b1;
                  data_d = acc_q;
                  end_d  = 1'b1;
                end
              end else begin
                se0_d = 1'b1;
              end
            end else begin
              se0_d      = 1'b0;
              prev_lvl_d = dm_i;
              if (ones_q == RUN_W'(STUFF_RUN)) begin
                ones_d = '0;
              end else begin
                ones_d = bit_v ? ones_q + RUN_W'(1) : '0;
                if (nbits_q == BIT_W'(BYTE_BITS - 1)) begin
                  nbits_d = '0;
                  acc_d   = '0;
                  if (left_q == '0) begin
                    ovf_d   = 1'b1;
                    state_d = RX_DRAIN;
                  end else begin
                    vld_d  = 1'b1;
                    data_d = acc_bit;
                    left_d = left_q - CNT_W'(1);
                  end
                end else begin
                  nbits_d = nbits_q + BIT_W'(1);
                  acc_d   = acc_bit;
                end
              end
            end
          end
        end
        RX_DRAIN: begin
          if (strobe_i && is_se0) state_d = RX_HUNT;
        end
        default: state_d = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_HUNT;
      prev_lvl_q <= 1'b1;
      last_k_q   <= 1'b0;
      last_j_q   <= 1'b0;
      slot_q     <= '0;
      ones_q     <= '0;
      nbits_q    <= '0;
      acc_q      <= '0;
      left_q     <= '0;
      se0_q      <= 1'b0;
      vld_q      <= 1'b0;
      data_q     <= '0;
      end_q      <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      prev_lvl_q <= prev_lvl_d;
      last_k_q   <= last_k_d;
      last_j_q   <= last_j_d;
      slot_q     <= slot_d;
      ones_q     <= ones_d;
      nbits_q    <= nbits_d;
      acc_q      <= acc_d;
      left_q     <= left_d;
      se0_q      <= se0_d;
      vld_q      <= vld_d;
      data_q     <= data_d;
      end_q      <= end_d;
      ovf_q      <= ovf_d;
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = data_q;
  assign pkt_end_o  = end_q;
  assign overflow_o = ovf_q;

  // R2: data reception is entered only out of the sync walk
  assert_enter_from_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_DATA && $past(state_q) != RX_DATA) |-> $past(state_q) == RX_SYNC);
  // R4: a discarded slot leaves the bit position unchanged and completes no byte
  assert_unstuff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_DATA && strobe_i && !is_se0 && !tx_active_i &&
     ones_q == RUN_W'(STUFF_RUN)) |=> ($stable(nbits_q) && !byte_vld_o));
  // R6: end of packet is a single-cycle pulse
  assert_end_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end_o |=> !pkt_end_o);
  // R8: overflow never comes with a byte or an end pulse
  assert_no_overflow_mix_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> (!byte_vld_o && !pkt_end_o));
  // R9: an active transmitter silences every output on the next cycle
  assert_tx_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active_i |=> (!byte_vld_o && !pkt_end_o && !overflow_o));
endmodule

// File: rtl/usbls_rx.sv
`timescale 1ps/1ps
module usbls_rx #(
  parameter int OVS         = 8,
  parameter int MAX_BYTES   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SYNC_SLOTS  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_active,
  input  logic       line_dp,
  input  logic       line_dm,
  output logic       rx_byte_vld,
  output logic [7:0] rx_byte,
  output logic       rx_pkt_end,
  output logic       rx_overflow
);
  logic [1:0] line_s;
  logic       strobe, dm_edge;

  usbls_rx_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b10)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({line_dm, line_dp}),
    .q_o  (line_s)
  );

  usbls_rx_phase #(
    .OVS(OVS)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .dm_i    (line_s[1]),
    .strobe_o(strobe),
    .edge_o  (dm_edge)
  );

  usbls_rx_deser #(
    .MAX_BYTES (MAX_BYTES),
    .SYNC_SLOTS(SYNC_SLOTS)
  ) u_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_active_i(tx_active),
    .strobe_i   (strobe),
    .edge_i     (dm_edge),
    .dm_i       (line_s[1]),
    .dp_i       (line_s[0]),
    .byte_vld_o (rx_byte_vld),
    .byte_o     (rx_byte),
    .pkt_end_o  (rx_pkt_end),
    .overflow_o (rx_overflow)
  );
endmodule

// File: tb/sim_usbls_rx.sv
`timescale 1ps/1ps
module sim_usbls_rx;
  localparam int CLK_PERIOD = 10000;
  localparam int OVS        = 8;
  localparam int MAX_BYTES  = 16;
  localparam int BIT_NOM    = CLK_PERIOD * OVS;
  localparam int DRIFT      = BIT_NOM / 100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_active;
  logic       dp_line, dm_line;
  logic       rx_byte_vld, rx_pkt_end, rx_overflow;
  logic [7:0] rx_byte;

  int         seq[$];
  logic [7:0] pkt[$];
  logic [7:0] got[$];
  int n_end, n_endbyte, n_ovf;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  usbls_rx #(.OVS(OVS), .MAX_BYTES(MAX_BYTES)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active),
    .line_dp(dp_line), .line_dm(dm_line),
    .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .rx_pkt_end(rx_pkt_end), .rx_overflow(rx_overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (rx_byte_vld) got.push_back(rx_byte);
      if (rx_pkt_end) n_end++;
      if (rx_pkt_end && rx_byte_vld) n_endbyte++;
      if (rx_overflow) n_ovf++;
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put_bit(input bit b, inout int lvl, inout int ones);
    if (b) ones++;
    else begin lvl = 3 - lvl; ones = 0; end
    seq.push_back(lvl);
    if (ones == 6) begin
      lvl = 3 - lvl;
      ones = 0;
      seq.push_back(lvl);
    end
  endtask

  // line codes: 0 = SE0, 1 = J, 2 = K
  task automatic build(input int extra_bits, input logic [7:0] extra_val, input int glitch_at);
    int lvl = 2, ones = 0, nb = 0;
    seq.delete();
    repeat (3) seq.push_back(1);
    for (int i = 0; i < 8; i++) seq.push_back((i == 7 || i % 2 == 0) ? 2 : 1);
    foreach (pkt[k]) begin
      for (int i = 0; i < 8; i++) begin
        if (nb == glitch_at) seq.push_back(0);
        put_bit(pkt[k][i], lvl, ones);
        nb++;
      end
    end
    for (int i = 0; i < extra_bits; i++) put_bit(extra_val[i], lvl, ones);
    seq.push_back(0);
    seq.push_back(0);
    repeat (4) seq.push_back(1);
  endtask

  task automatic play(input int bit_ps);
    foreach (seq[i]) begin
      dm_line = (seq[i] == 1);
      dp_line = (seq[i] == 2);
      #(bit_ps);
    end
    dm_line = 1'b1;
    dp_line = 1'b0;
    repeat (20 * OVS) @(posedge clk);
  endtask

  task automatic clear_mon();
    got.delete();
    n_end = 0; n_endbyte = 0; n_ovf = 0;
  endtask

  task automatic run(input string req, input int bit_ps, input int extra_bits,
                     input logic [7:0] extra_val, input int glitch_at,
                     input bit exp_ovf, input bit quiet);
    int n_exp;
    logic [7:0] ev;
    clear_mon();
    build(extra_bits, extra_val, glitch_at);
    play(bit_ps);
    if (quiet) begin
      chk(req, "bytes", got.size(), 0);
      chk(req, "end", n_end, 0);
      chk(req, "ovf", n_ovf, 0);
    end else if (exp_ovf) begin
      chk(req, "bytes", got.size(), MAX_BYTES);
      chk(req, "ovf", n_ovf, 1);
      chk(req, "end", n_end, 0);
      for (int i = 0; i < got.size() && i < MAX_BYTES; i++) chk(req, "data", got[i], pkt[i]);
    end else begin
      n_exp = pkt.size() + ((extra_bits > 0) ? 1 : 0);
      chk(req, "bytes", got.size(), n_exp);
      for (int i = 0; i < got.size() && i < n_exp; i++) begin
        if (i < pkt.size()) ev = pkt[i];
        else ev = extra_val & 8'((1 << extra_bits) - 1);
        chk(req, "data", got[i], ev);
      end
      chk(req, "end", n_end, 1);
      chk(req, "end_with_byte", n_endbyte, (extra_bits > 0) ? 1 : 0);
      chk(req, "ovf", n_ovf, 0);
    end
  endtask

  task automatic run_raw(input string req);
    clear_mon();
    play(BIT_NOM);
    chk(req, "bytes", got.size(), 0);
    chk(req, "end", n_end, 0);
    chk(req, "ovf", n_ovf, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    int len, d;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; tx_active = 1'b0; dm_line = 1'b1; dp_line = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1", "vld in reset", rx_byte_vld, 0);
    chk("R1", "end in reset", rx_pkt_end, 0);
    chk("R1", "ovf in reset", rx_overflow, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1", "vld idle", rx_byte_vld, 0);
    chk("R1", "end idle", rx_pkt_end, 0);

    pkt = '{8'hC3, 8'h5A, 8'h01};
    run("R3", BIT_NOM, 0, 8'h00, -1, 0, 0);
    pkt = '{8'h00, 8'h00, 8'h00};
    run("R3", BIT_NOM, 0, 8'h00, -1, 0, 0);
    pkt = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run("R4", BIT_NOM, 0, 8'h00, -1, 0, 0);
    pkt = '{8'h3F, 8'hFC, 8'h7E, 8'hE0};
    run("R4", BIT_NOM + DRIFT, 0, 8'h00, -1, 0, 0);

    pkt = '{8'hA5};
    run("R6", BIT_NOM, 3, 8'h05, -1, 0, 0);
    pkt = '{8'h81, 8'h42};
    run("R6", BIT_NOM - DRIFT, 5, 8'h1B, -1, 0, 0);

    pkt = '{8'h12, 8'h34, 8'h56};
    run("R7", BIT_NOM, 0, 8'h00, 11, 0, 0);

    pkt.delete();
    for (int i = 0; i < MAX_BYTES + 2; i++) pkt.push_back(8'($urandom));
    run("R8", BIT_NOM, 0, 8'h00, -1, 1, 0);
    pkt = '{8'h69, 8'h96};
    run("R8", BIT_NOM, 0, 8'h00, -1, 0, 0);

    tx_active = 1'b1;
    pkt = '{8'hD2, 8'h2D};
    run("R9", BIT_NOM, 0, 8'h00, -1, 0, 1);
    tx_active = 1'b0;
    repeat (4) @(negedge clk);

    seq = '{1, 1, 2, 1, 1, 2, 1, 1, 2, 1, 1, 1};
    run_raw("R2");
    seq.delete();
    seq.push_back(1);
    for (int i = 0; i < 16; i++) seq.push_back((i % 2 == 0) ? 2 : 1);
    seq.push_back(1);
    run_raw("R2");
    pkt = '{8'hE1, 8'h1E};
    run("R2", BIT_NOM, 0, 8'h00, -1, 0, 0);

    for (int p = 0; p < 12; p++) begin
      len = 1 + int'($urandom % MAX_BYTES);
      pkt.delete();
      for (int i = 0; i < len; i++) begin
        if ($urandom % 4 == 0) pkt.push_back(8'hFF);
        else pkt.push_back(8'($urandom));
      end
      d = int'($urandom % 3) - 1;
      run((d == 0) ? "R3" : "R5", BIT_NOM + d * DRIFT, 0, 8'h00, -1, 0, 0);
    end
    summary();
  end
endmodule